// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Instruction Protection

This block collects interrupt requests for a processor sequencer from eight sources. The sources are a reset request, a parameterized number of external maskable lines, a software trap, a timer event, and the receive and transmit events of a serial port. Each request is latched as a pending flag. Every cycle the block picks the highest-priority pending source that is allowed to interrupt. It reports that source as a registered take pulse, a one-hot acknowledge and a vector address. Vectors sit two words apart, so a branch instruction fits at each entry.

A take is held back for as long as the current instruction is still running. The sequencer signals the end of an instruction. It also reports whether the memory bus is ready, and whether a repeat loop is still counting. A take happens only when the instruction has ended, the bus is ready and no repeat loop is running. This protects repeated instructions and instructions stretched by wait states. The reset request is the only source that skips this wait.

The maskable sources need their mask bit and the global enable. The trap and the reset request need neither. Every take clears the global enable, and software must set it again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `take_o` is 0, `ack_o` is 0, `vector_o` is 0 and `gie_o` is 0. All pending flags are cleared.
- R2: Source indices, from highest to lowest priority, are: 0 reset request, 1..NUM_EXT the external lines (`ext_irq[0]` first), NUM_EXT+1 trap, NUM_EXT+2 timer, NUM_EXT+3 serial receive, NUM_EXT+4 serial transmit. When several sources can be taken, the lowest index is taken.
- R3: On a take, `vector_o` equals VEC_BASE + 2 × index of the taken source. Between takes, `vector_o` holds its last value.
- R4: A request high at a clock edge sets that source's pending flag. The flag stays set until that same source is taken. Takes of other sources leave it alone.
- R5: A source other than the reset request is taken only at an edge where `insn_end` is 1, `bus_ready` is 1 and `rpt_busy` is 0. The reset request is taken whatever these inputs are.
- R6: The mask bits are arranged as follows: `irq_mask[k]` gates `ext_irq[k]` for k < NUM_EXT, `irq_mask[NUM_EXT]` gates the timer, `irq_mask[NUM_EXT+1]` gates receive, and `irq_mask[NUM_EXT+2]` gates transmit. A maskable source is taken only when its mask bit is 1 and `gie_o` is 1.
- R7: The reset request and the trap are taken whatever the values of `irq_mask` and `gie_o`.
- R8: `gie_o` is set by `gie_set` and cleared by `gie_clr`, and set wins if both are high. Any take clears `gie_o` at the edge where the take registers, overriding `gie_set`.
- R9: `take_o` and `ack_o` are registered. A pending source becomes visible one edge after the edge that latched it. `ack_o` is one-hot with the taken index while `take_o` is 1, and zero otherwise.
- R10: A source held back by its mask or by the global enable stays pending, and is taken once it is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_irq | input | 1 | Reset interrupt request (index 0) |
| ext_irq | input | NUM_EXT | External maskable requests |
| trap_irq | input | 1 | Software trap request |
| tmr_irq | input | 1 | Timer event |
| srx_irq | input | 1 | Serial receive event |
| stx_irq | input | 1 | Serial transmit event |
| irq_mask | input | NUM_EXT+3 | Mask bits, 1 enables the source |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| insn_end | input | 1 | Current cycle ends the instruction |
| bus_ready | input | 1 | External bus ready, 0 stretches the instruction |
| rpt_busy | input | 1 | Repeat loop still counting |
| take_o | output | 1 | Interrupt taken this cycle |
| vector_o | output | VEC_W | Vector address of the taken source |
| ack_o | output | NUM_EXT+5 | One-hot acknowledge by source index |
| gie_o | output | 1 | Global enable state |

## Verification
The bench builds the block with three external lines, a 12-bit vector and VEC_BASE set to 32. The non-zero base shows that the base offset and the two-word stride add correctly, and that the result is not just the index shifted left. With three external lines the sources reach eight, so every priority position can be reached. This includes a trap overtaking a higher external line while the global enable is off. Directed sequences hold the boundary inputs low one at a time, mask one source and later unmask it, and put a take and `gie_set` on the same edge. A long random phase then compares every output with the reference model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // distance in words between consecutive vector entries
  localparam int unsigned VEC_STRIDE = 2;
  // sources besides the external lines and the reset request
  localparam int unsigned N_INTERNAL = 4;
  // reset request always occupies index 0
  localparam int unsigned IDX_RESET  = 0;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) pend_o[g] <= 1'b0;
      else     pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]); // R4
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSRC-1:0]  grant_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  assign grant_o = found_o ? (NSRC'(1) << idx_o) : '0;

  AST_GRANT_IS_CAND: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |-> (|(grant_o & cand_i))); // R2
  AST_NO_HIGHER_CAND: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |-> (((grant_o - NSRC'(1)) & cand_i) == '0)); // R2

endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic gie_o
);

  always_ff @(posedge clk) begin
    if (rst)         gie_o <= 1'b0;
    else if (take_i) gie_o <= 1'b0;
    else if (set_i)  gie_o <= 1'b1;
    else if (clr_i)  gie_o <= 1'b0;
  end

  AST_GIE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i && !take_i) |=> gie_o); // R8
  AST_GIE_TAKE_CLR: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !gie_o); // R8

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_EXT  = 3,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 0,
  localparam int unsigned NSRC    = NUM_EXT + irq_pkg::N_INTERNAL + 1,
  localparam int unsigned NMASK   = NUM_EXT + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_irq,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic               trap_irq,
  input  logic               tmr_irq,
  input  logic               srx_irq,
  input  logic               stx_irq,
  input  logic [NMASK-1:0]   irq_mask,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               insn_end,
  input  logic               bus_ready,
  input  logic               rpt_busy,
  output logic               take_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic [NSRC-1:0]    ack_o,
  output logic               gie_o
);

  localparam int unsigned IDX_W    = $clog2(NSRC);
  localparam int unsigned IDX_TRAP = NUM_EXT + 1;
  localparam logic [NSRC-1:0] RST_ONLY = NSRC'(1) << irq_pkg::IDX_RESET;
  localparam logic [NSRC-1:0] MASKABLE = ~(RST_ONLY | (NSRC'(1) << IDX_TRAP));
  localparam logic [VEC_W-1:0] BASE_V  = VEC_W'(VEC_BASE);

  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  allow;
  logic [NSRC-1:0]  cand;
  logic [NSRC-1:0]  grant;
  logic [IDX_W-1:0] pick_idx;
  logic             found;
  logic             boundary;
  logic [VEC_W-1:0] vec_next;

  assign req = {stx_irq, srx_irq, tmr_irq, trap_irq, ext_irq, rst_irq};

  // instruction is fully retired: no wait state, no pending repeat
  assign boundary = insn_end & bus_ready & ~rpt_busy;

  for (genvar g = 0; g < NSRC; g++) begin : g_allow
    if (g == irq_pkg::IDX_RESET || g == IDX_TRAP) begin : g_nmi
      assign allow[g] = 1'b1;
    end else if (g <= NUM_EXT) begin : g_ext
      assign allow[g] = irq_mask[g-1] & gie_o;
    end else begin : g_int
      assign allow[g] = irq_mask[g-2] & gie_o;
    end
  end

  assign cand = pend & allow & (boundary ? {NSRC{1'b1}} : RST_ONLY);

  irq_pending #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req),
    .clr_i  (grant),
    .pend_o (pend)
  );

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .cand_i  (cand),
    .found_o (found),
    .idx_o   (pick_idx),
    .grant_o (grant)
  );

  irq_gie_ctrl u_gie (
    .clk    (clk),
    .rst    (rst),
    .set_i  (gie_set),
    .clr_i  (gie_clr),
    .take_i (found),
    .gie_o  (gie_o)
  );

  assign vec_next = BASE_V + VEC_W'(pick_idx) * VEC_W'(irq_pkg::VEC_STRIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o   <= 1'b0;
      ack_o    <= '0;
      vector_o <= '0;
    end else begin
      take_o <= found;
      ack_o  <= grant;
      if (found) vector_o <= vec_next;
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (take_o && !ack_o[irq_pkg::IDX_RESET]) |-> $past(boundary)); // R5
  AST_MASKED_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    (take_o && (|(ack_o & MASKABLE))) |-> $past(gie_o)); // R6
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !gie_o); // R8
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $onehot(ack_o)); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (ack_o == '0)); // R9
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!take_o && !$past(rst)) |-> $stable(vector_o)); // R3

endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int N_EXT = 3;
  localparam int NS    = N_EXT + 5;
  localparam int NM    = N_EXT + 3;
  localparam int VW    = 12;
  localparam int BASE  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_irq = 0, trap_irq = 0, tmr_irq = 0, srx_irq = 0, stx_irq = 0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic [NM-1:0] irq_mask = '0;
  logic gie_set = 0, gie_clr = 0, insn_end = 1, bus_ready = 1, rpt_busy = 0;
  logic take_o, gie_o;
  logic [VW-1:0] vector_o;
  logic [NS-1:0] ack_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit [NS-1:0] m_pend;
  bit m_gie, m_take;
  bit [NS-1:0] m_ack;
  int m_vec;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NUM_EXT(N_EXT), .VEC_W(VW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .rst_irq(rst_irq), .ext_irq(ext_irq),
    .trap_irq(trap_irq), .tmr_irq(tmr_irq), .srx_irq(srx_irq), .stx_irq(stx_irq),
    .irq_mask(irq_mask), .gie_set(gie_set), .gie_clr(gie_clr),
    .insn_end(insn_end), .bus_ready(bus_ready), .rpt_busy(rpt_busy),
    .take_o(take_o), .vector_o(vector_o), .ack_o(ack_o), .gie_o(gie_o));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mask_bit(int i);
    return (i <= N_EXT) ? i - 1 : i - 2;
  endfunction

  task automatic model_step();
    bit bnd, ok;
    int pick;
    bit [NS-1:0] req;
    if (rst) begin
      m_pend = '0; m_gie = 0; m_take = 0; m_ack = '0; m_vec = 0;
      return;
    end
    bnd  = insn_end && bus_ready && !rpt_busy;
    req  = {stx_irq, srx_irq, tmr_irq, trap_irq, ext_irq, rst_irq};
    pick = -1;
    for (int i = 0; i < NS; i++) begin
      if (pick < 0 && m_pend[i]) begin
        if (i == 0) ok = 1;
        else if (!bnd) ok = 0;
        else if (i == N_EXT + 1) ok = 1;
        else ok = m_gie && irq_mask[mask_bit(i)];
        if (ok) pick = i;
      end
    end
    if (pick >= 0) begin
      m_take = 1; m_ack = '0; m_ack[pick] = 1'b1;
      m_vec = BASE + 2 * pick; m_pend[pick] = 1'b0; m_gie = 0;
    end else begin
      m_take = 0; m_ack = '0;
      if (gie_set) m_gie = 1;
      else if (gie_clr) m_gie = 0;
    end
    m_pend = m_pend | req;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R9 take", int'(take_o), int'(m_take));
    chk("R2 ack", int'(ack_o), int'(m_ack));
    chk("R3 vector", int'(vector_o), m_vec);
    chk("R8 gie", int'(gie_o), int'(m_gie));
  endtask

  task automatic enable_gie();
    gie_set = 1; tick(); gie_set = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick(); tick();
    // R1: reset state
    chk("R1 take", int'(take_o), 0);
    chk("R1 ack", int'(ack_o), 0);
    chk("R1 vector", int'(vector_o), 0);
    chk("R1 gie", int'(gie_o), 0);
    rst = 0; tick();
    chk("R1 idle after reset", int'(take_o), 0);

    // single external request, R3 R9
    irq_mask = '1;
    enable_gie();
    chk("R8 gie set", int'(gie_o), 1);
    ext_irq[0] = 1; tick(); ext_irq[0] = 0;
    chk("R9 no take on latch edge", int'(take_o), 0);
    tick();
    chk("R9 take ext0", int'(take_o), 1);
    chk("R3 vector ext0", int'(vector_o), BASE + 2);
    chk("R9 ack ext0", int'(ack_o), 'h02);
    chk("R8 gie cleared by take", int'(gie_o), 0);

    // priority and trap bypass, R2 R4 R7
    enable_gie();
    ext_irq = 3'b011; trap_irq = 1; stx_irq = 1; tick();
    ext_irq = '0; trap_irq = 0; stx_irq = 0;
    tick();
    chk("R2 first is ext0", int'(ack_o), 'h02);
    tick();
    chk("R7 trap without gie", int'(ack_o), 'h10);
    tick();
    chk("R6 ext1 waits for gie", int'(take_o), 0);
    enable_gie();
    chk("R6 no take on gie edge", int'(take_o), 0);
    tick();
    chk("R4 ext1 still pending", int'(ack_o), 'h04);
    enable_gie(); tick();
    chk("R2 transmit last", int'(ack_o), 'h80);
    chk("R3 vector transmit", int'(vector_o), BASE + 14);

    // instruction protection, R5
    enable_gie();
    tmr_irq = 1; insn_end = 0; tick(); tmr_irq = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R5 held mid-instruction", int'(take_o), 0);
    end
    insn_end = 1; bus_ready = 0; tick();
    chk("R5 held by wait state", int'(take_o), 0);
    bus_ready = 1; rpt_busy = 1; tick(); tick();
    chk("R5 held by repeat", int'(take_o), 0);
    rpt_busy = 0; tick();
    chk("R5 taken at boundary", int'(ack_o), 'h20);
    chk("R3 vector timer", int'(vector_o), BASE + 10);

    // masked then unmasked, R6 R10
    irq_mask[4] = 0; enable_gie();
    srx_irq = 1; tick(); srx_irq = 0;
    tick(); tick();
    chk("R6 masked receive held", int'(take_o), 0);
    irq_mask[4] = 1; tick();
    chk("R10 receive after unmask", int'(ack_o), 'h40);

    // reset request ignores everything, R5 R7
    irq_mask = '0; insn_end = 0; bus_ready = 0;
    rst_irq = 1; tick(); rst_irq = 0; tick();
    chk("R7 reset request taken", int'(ack_o), 'h01);
    chk("R5 reset bypasses boundary", int'(vector_o), BASE);
    insn_end = 1; bus_ready = 1;

    // take versus set on the same edge, set versus clear, R8
    trap_irq = 1; tick(); trap_irq = 0;
    gie_set = 1; tick(); gie_set = 0;
    chk("R8 take overrides set", int'(gie_o), 0);
    gie_set = 1; gie_clr = 1; tick(); gie_set = 0; gie_clr = 0;
    chk("R8 set wins over clear", int'(gie_o), 1);
    gie_clr = 1; tick(); gie_clr = 0;
    chk("R8 clear", int'(gie_o), 0);

    // random phase, compared with the model every clock
    for (int n = 0; n < 4000; n++) begin
      rst       = ($urandom_range(0, 599) == 0);
      rst_irq   = ($urandom_range(0, 199) == 0);
      ext_irq   = '0;
      for (int e = 0; e < N_EXT; e++) ext_irq[e] = ($urandom_range(0, 15) == 0);
      trap_irq  = ($urandom_range(0, 31) == 0);
      tmr_irq   = ($urandom_range(0, 15) == 0);
      srx_irq   = ($urandom_range(0, 15) == 0);
      stx_irq   = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 19) == 0) irq_mask = NM'($urandom());
      gie_set   = ($urandom_range(0, 3) == 0);
      gie_clr   = ($urandom_range(0, 15) == 0);
      insn_end  = ($urandom_range(0, 3) != 0);
      bus_ready = ($urandom_range(0, 3) != 0);
      rpt_busy  = ($urandom_range(0, 7) == 0);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule